// File: doc/BRIEF.md
# DDR Write Request Master

This block sits on the user side of a DDR memory controller and turns write jobs into controller write postings. A job holds a 34-bit address and an 8-bit burst length. The job is checked and parked in a one-entry slot. It is then driven onto the controller's request, address and burst lines. While the controller signals busy, the posting stays frozen. Postings that the controller accepts are always at least five interface cycles apart. A job whose burst length is outside the legal window is dropped, and it raises a sticky error flag.

Write data does not travel with the request. The user pushes 144-bit beats, each with an 18-bit byte mask, into a beat queue in posting order. Each cycle in which the controller raises its early data strobe takes one beat from the queue. That beat goes through a fixed pipeline and appears on the data and mask outputs exactly three cycles later. If a strobe arrives while the queue is empty, a sticky underrun flag is set and a fully masked, zero beat is sent in that slot. Every output is registered, and reset is synchronous and active high.

Top module: `wrm_write_master`

## Requirements
- R1: After reset, `mc_wr_req` is 0, `mc_wdata` is 0, `mc_wmask` is all ones, `len_err` and `underrun` are 0, and `job_ready` and `beat_ready` are 1.
- R2: While `mc_wr_req` is 1 and `mc_busy` is 1, the next cycle still shows `mc_wr_req` at 1 with `mc_addr` and `mc_burst` unchanged.
- R3: A legal job taken in cycle c appears as a posting in cycle c+2 when the spacing allows. A posting is accepted in a cycle where `mc_wr_req` is 1 and `mc_busy` is 0. After an acceptance in cycle a, `mc_wr_req` stays 0 in cycles a+1 to a+4, and the next pending job is posted in cycle a+5.
- R4: The spacing count restarts only on an accepted posting. Cycles in which a posting waits under busy do not restart it, so the next posting still follows the acceptance cycle by exactly five cycles.
- R5: A job with burst length from 4 to 252 inclusive is posted with its address and length. A job with any other length is never posted, and it sets `len_err`, which stays 1 until reset.
- R6: A beat taken by an early strobe in cycle s appears on `mc_wdata` and `mc_wmask` in cycle s+3. Beats leave in the order they were pushed, one per strobe cycle. A mask bit of 1 means that byte lane is not written.
- R7: A strobe while the beat queue is empty sets `underrun` from the next cycle on; it stays set until reset. Three cycles after that strobe, the data outputs show zero data with the mask all ones.
- R8: In any cycle that is not three cycles after a strobe, `mc_wdata` is 0 and `mc_wmask` is all ones.
- R9: The beat queue holds 16 beats. When it is full, `beat_ready` is 0 and a pushed beat is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| job_valid | input | 1 | Write job offered |
| job_addr | input | 34 | Job start address |
| job_len | input | 8 | Job burst length in beats |
| job_ready | output | 1 | Job slot free |
| beat_valid | input | 1 | Write beat offered |
| beat_data | input | 144 | Beat data |
| beat_mask | input | 18 | Beat byte mask, 1 = lane not written |
| beat_ready | output | 1 | Beat queue not full |
| mc_busy | input | 1 | Controller cannot accept a posting |
| mc_wreq_early | input | 1 | Controller early data strobe |
| mc_wr_req | output | 1 | Write posting request |
| mc_addr | output | 34 | Posting address |
| mc_burst | output | 8 | Posting burst length |
| mc_wdata | output | 144 | Write data to controller |
| mc_wmask | output | 18 | Byte mask to controller |
| len_err | output | 1 | Sticky illegal-length flag |
| underrun | output | 1 | Sticky empty-queue strobe flag |

## Verification
The hardest case to reach is a second job that is already pending while the first posting is held by busy. This is the only way to show that the spacing count runs from the acceptance cycle and not from the first attempt. The stimulus asserts busy just before the first posting appears and holds it for two edges. It loads the second job during the stall, then releases busy and expects the second posting exactly five cycles after the release edge. A full beat queue followed by one strobe more than the queue holds drives the underrun path and the discard-when-full path in one stream.

// File: rtl/wrm_pkg.sv
`timescale 1ns/1ps
package wrm_pkg;
    localparam int ADDR_W     = 34;
    localparam int LEN_W      = 8;
    localparam int DATA_W     = 144;
    localparam int MASK_W     = DATA_W / 8;
    localparam int GAP_CYC    = 5;
    localparam int DATA_LEAD  = 3;
    localparam int BEAT_DEPTH = 16;
    localparam int LEN_MIN    = 4;
    localparam int LEN_MAX    = 252;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } wr_job_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [MASK_W-1:0] mask;
    } wr_beat_t;

    localparam wr_beat_t IDLE_BEAT = '{data: '0, mask: '1};

    function automatic logic len_legal(input logic [LEN_W-1:0] l);
        return (l >= LEN_W'(LEN_MIN)) && (l <= LEN_W'(LEN_MAX));
    endfunction
endpackage

// File: rtl/wrm_req_ctrl.sv
`timescale 1ns/1ps
module wrm_req_ctrl
    import wrm_pkg::*;
#(
    parameter int GAP = GAP_CYC
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    job_valid,
    input  wr_job_t job_in,
    output logic    job_ready,
    input  logic    busy,
    output logic    req_o,
    output wr_job_t job_o,
    output logic    len_err_o
);
    localparam int CW = $clog2(GAP + 1);

    logic          pend_v;
    wr_job_t       pend;
    logic [CW-1:0] gap_cnt;
    logic          req_q;
    wr_job_t       job_q;
    logic          err_q;
    logic          take, accept, launch;

    assign job_ready = !pend_v;
    assign take      = job_valid && !pend_v;
    assign accept    = req_q && !busy;
    assign launch    = pend_v && !req_q && (gap_cnt <= CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v  <= 1'b0;
            pend    <= '0;
            gap_cnt <= '0;
            req_q   <= 1'b0;
            job_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            if (take) begin
                if (len_legal(job_in.len)) begin
                    pend_v <= 1'b1;
                    pend   <= job_in;
                end else begin
                    err_q <= 1'b1;
                end
            end
            if (launch) begin
                pend_v <= 1'b0;
                req_q  <= 1'b1;
                job_q  <= pend;
            end
            if (accept) begin
                req_q   <= 1'b0;
                gap_cnt <= CW'(GAP - 1);
            end else if (gap_cnt != '0) begin
                gap_cnt <= gap_cnt - CW'(1);
            end
        end
    end

    assign req_o     = req_q;
    assign job_o     = job_q;
    assign len_err_o = err_q;
endmodule

// File: rtl/wrm_beat_fifo.sv
`timescale 1ns/1ps
module wrm_beat_fifo
    import wrm_pkg::*;
#(
    parameter int DEPTH = BEAT_DEPTH
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  wr_beat_t din,
    output logic     full,
    input  logic     pop,
    output wr_beat_t dout,
    output logic     empty
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    wr_beat_t         mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CNT_W-1:0] count;
    logic             push_ok, pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= next_ptr(wp);
            if (pop_ok)  rp <= next_ptr(rp);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/wrm_data_pipe.sv
`timescale 1ns/1ps
module wrm_data_pipe
    import wrm_pkg::*;
#(
    parameter int LEAD = DATA_LEAD
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  wr_beat_t din,
    output wr_beat_t dout
);
    wr_beat_t stg [LEAD];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= IDLE_BEAT;
        else     stg[0] <= load ? din : IDLE_BEAT;
    end

    for (genvar i = 1; i < LEAD; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= IDLE_BEAT;
            else     stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[LEAD-1];
endmodule

// File: rtl/wrm_write_master.sv
`timescale 1ns/1ps
module wrm_write_master
    import wrm_pkg::*;
#(
    parameter int GAP   = GAP_CYC,
    parameter int LEAD  = DATA_LEAD,
    parameter int DEPTH = BEAT_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              job_valid,
    input  logic [ADDR_W-1:0] job_addr,
    input  logic [LEN_W-1:0]  job_len,
    output logic              job_ready,
    input  logic              beat_valid,
    input  logic [DATA_W-1:0] beat_data,
    input  logic [MASK_W-1:0] beat_mask,
    output logic              beat_ready,
    input  logic              mc_busy,
    input  logic              mc_wreq_early,
    output logic              mc_wr_req,
    output logic [ADDR_W-1:0] mc_addr,
    output logic [LEN_W-1:0]  mc_burst,
    output logic [DATA_W-1:0] mc_wdata,
    output logic [MASK_W-1:0] mc_wmask,
    output logic              len_err,
    output logic              underrun
);
    wr_job_t  job_in, job_out;
    wr_beat_t beat_in, head, beat_out;
    logic     q_full, q_empty, pop, under_q;

    assign job_in  = '{addr: job_addr, len: job_len};
    assign beat_in = '{data: beat_data, mask: beat_mask};
    assign pop     = mc_wreq_early && !q_empty;

    wrm_req_ctrl #(.GAP(GAP)) u_req (
        .clk       (clk),
        .rst       (rst),
        .job_valid (job_valid),
        .job_in    (job_in),
        .job_ready (job_ready),
        .busy      (mc_busy),
        .req_o     (mc_wr_req),
        .job_o     (job_out),
        .len_err_o (len_err)
    );

    wrm_beat_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (beat_valid),
        .din   (beat_in),
        .full  (q_full),
        .pop   (pop),
        .dout  (head),
        .empty (q_empty)
    );

    wrm_data_pipe #(.LEAD(LEAD)) u_pipe (
        .clk  (clk),
        .rst  (rst),
        .load (pop),
        .din  (head),
        .dout (beat_out)
    );

    always_ff @(posedge clk) begin
        if (rst)                           under_q <= 1'b0;
        else if (mc_wreq_early && q_empty) under_q <= 1'b1;
    end

    assign beat_ready = !q_full;
    assign mc_addr    = job_out.addr;
    assign mc_burst   = job_out.len;
    assign mc_wdata   = beat_out.data;
    assign mc_wmask   = beat_out.mask;
    assign underrun   = under_q;
endmodule

// File: rtl/wrm_write_master_chk.sv
`timescale 1ns/1ps
module wrm_write_master_chk
    import wrm_pkg::*;
#(
    parameter int GAP  = GAP_CYC,
    parameter int LEAD = DATA_LEAD
) (
    input logic              clk,
    input logic              rst,
    input logic              mc_busy,
    input logic              mc_wreq_early,
    input logic              mc_wr_req,
    input logic [ADDR_W-1:0] mc_addr,
    input logic [LEN_W-1:0]  mc_burst,
    input logic [DATA_W-1:0] mc_wdata,
    input logic [MASK_W-1:0] mc_wmask,
    input logic              underrun
);
    logic [7:0]      since;
    logic [LEAD-1:0] strb_sr;

    always_ff @(posedge clk) begin
        if (rst)                        since <= 8'(GAP);
        else if (mc_wr_req && !mc_busy) since <= 8'd1;
        else if (since != 8'hFF)        since <= since + 8'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) strb_sr <= '0;
        else begin
            strb_sr[0] <= mc_wreq_early;
            for (int i = 1; i < LEAD; i++) strb_sr[i] <= strb_sr[i-1];
        end
    end

    AST_HOLD_ON_BUSY: assert property (@(posedge clk) disable iff (rst)
        (mc_wr_req && mc_busy) |=> (mc_wr_req && $stable(mc_addr) && $stable(mc_burst))); // R2

    AST_POST_SPACING: assert property (@(posedge clk) disable iff (rst)
        (mc_wr_req && !mc_busy) |-> (since >= 8'(GAP))); // R3

    AST_LEGAL_BURST: assert property (@(posedge clk) disable iff (rst)
        mc_wr_req |-> ((mc_burst >= LEN_W'(LEN_MIN)) && (mc_burst <= LEN_W'(LEN_MAX)))); // R5

    AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (rst)
        !strb_sr[LEAD-1] |-> ((mc_wmask == '1) && (mc_wdata == '0))); // R8

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun); // R7
endmodule

bind wrm_write_master wrm_write_master_chk #(.GAP(GAP), .LEAD(LEAD)) u_chk (.*);

// File: tb/test_wrm_write_master.sv
`timescale 1ns/1ps
module test_wrm_write_master;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         job_valid = 1'b0;
    logic [33:0]  job_addr = '0;
    logic [7:0]   job_len = '0;
    logic         job_ready;
    logic         beat_valid = 1'b0;
    logic [143:0] beat_data = '0;
    logic [17:0]  beat_mask = '0;
    logic         beat_ready;
    logic         mc_busy = 1'b0;
    logic         mc_wreq_early = 1'b0;
    logic         mc_wr_req;
    logic [33:0]  mc_addr;
    logic [7:0]   mc_burst;
    logic [143:0] mc_wdata;
    logic [17:0]  mc_wmask;
    logic         len_err;
    logic         underrun;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    wrm_write_master i_wrm_write_master (.*);

    // vector: {address, burst length, expected to be posted}
    localparam logic [42:0] VEC [8] = '{
        {34'h0_0000_1000, 8'd4,   1'b1},
        {34'h3_FFFF_FFC0, 8'd252, 1'b1},
        {34'h0_0000_2000, 8'd3,   1'b0},
        {34'h1_2345_6780, 8'd100, 1'b1},
        {34'h0_0000_3000, 8'd253, 1'b0},
        {34'h0_0000_4000, 8'd0,   1'b0},
        {34'h2_0000_0040, 8'd8,   1'b1},
        {34'h0_0000_5000, 8'd255, 1'b0}
    };

    logic [33:0] va, held_addr;
    logic [7:0]  vl;
    logic        vok;
    logic        bad_seen = 1'b0;

    function automatic logic [143:0] bdat(input int i);
        return {9{16'(16'hC000 + i)}};
    endfunction

    function automatic logic [17:0] bmsk(input int i);
        return 18'(i * 37 + 5);
    endfunction

    task automatic check(input string req, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic submit(input logic [33:0] a, input logic [7:0] l);
        @(negedge clk);
        job_valid = 1'b1;
        job_addr  = a;
        job_len   = l;
        @(negedge clk);
        job_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 req",        192'(mc_wr_req),  192'(0));
        check("R1 wdata",      192'(mc_wdata),   192'(0));
        check("R1 wmask",      192'(mc_wmask),   192'(18'h3FFFF));
        check("R1 len_err",    192'(len_err),    192'(0));
        check("R1 underrun",   192'(underrun),   192'(0));
        check("R1 job_ready",  192'(job_ready),  192'(1));
        check("R1 beat_ready", 192'(beat_ready), 192'(1));

        // R5 table walk: legal lengths posted, illegal ones dropped and flagged
        for (int v = 0; v < 8; v++) begin
            {va, vl, vok} = VEC[v];
            submit(va, vl);
            if (!vok) bad_seen = 1'b1;
            check("R5 len_err", 192'(len_err), 192'(bad_seen));
            @(negedge clk);
            check("R5 posted", 192'(mc_wr_req), 192'(vok));
            if (vok) begin
                check("R5 addr",  192'(mc_addr),  192'(va));
                check("R5 burst", 192'(mc_burst), 192'(vl));
            end
            repeat (6) @(negedge clk);
        end

        // R3 spacing: accepted at c2, next posting exactly at c7
        submit(34'h0_0000_A000, 8'd16);
        @(negedge clk);
        check("R3 first posting", 192'(mc_wr_req), 192'(1));
        job_valid = 1'b1;
        job_addr  = 34'h0_0000_B000;
        job_len   = 8'd32;
        for (int k = 3; k <= 6; k++) begin
            @(negedge clk);
            job_valid = 1'b0;
            check("R3 gap low", 192'(mc_wr_req), 192'(0));
        end
        @(negedge clk);
        check("R3 second posting", 192'(mc_wr_req), 192'(1));
        check("R3 second addr",    192'(mc_addr),   192'(34'h0_0000_B000));
        repeat (6) @(negedge clk);

        // R2/R4: posting stalled by busy, next one five cycles after acceptance
        @(negedge clk);
        job_valid = 1'b1;
        job_addr  = 34'h0_0000_C000;
        job_len   = 8'd12;
        @(negedge clk);
        job_valid = 1'b0;
        mc_busy   = 1'b1;
        @(negedge clk);
        check("R2 posted under busy", 192'(mc_wr_req), 192'(1));
        held_addr = mc_addr;
        job_valid = 1'b1;
        job_addr  = 34'h0_0000_D000;
        job_len   = 8'd20;
        @(negedge clk);
        job_valid = 1'b0;
        check("R2 req held",  192'(mc_wr_req), 192'(1));
        check("R2 addr held", 192'(mc_addr),   192'(held_addr));
        check("R2 len held",  192'(mc_burst),  192'(8'd12));
        @(negedge clk);
        check("R2 req held 2", 192'(mc_wr_req), 192'(1));
        mc_busy = 1'b0;
        for (int k = 5; k <= 8; k++) begin
            @(negedge clk);
            check("R4 gap low", 192'(mc_wr_req), 192'(0));
        end
        @(negedge clk);
        check("R4 next posting", 192'(mc_wr_req), 192'(1));
        check("R4 next addr",    192'(mc_addr),   192'(34'h0_0000_D000));
        check("R4 next len",     192'(mc_burst),  192'(8'd20));
        repeat (6) @(negedge clk);

        // R6/R8: three beats, three strobes, data three cycles later
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            beat_valid = 1'b1;
            beat_data  = bdat(i);
            beat_mask  = bmsk(i);
        end
        @(negedge clk);
        beat_valid = 1'b0;
        mc_wreq_early = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k == 3) mc_wreq_early = 1'b0;
            if (k < 3 || k == 6) begin
                check("R8 idle data", 192'(mc_wdata), 192'(0));
                check("R8 idle mask", 192'(mc_wmask), 192'(18'h3FFFF));
            end else begin
                check("R6 data", 192'(mc_wdata), 192'(bdat(k - 3)));
                check("R6 mask", 192'(mc_wmask), 192'(bmsk(k - 3)));
            end
        end

        // R9: fill queue, extra push discarded; R7: one strobe past empty
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            check("R9 ready before full", 192'(beat_ready), 192'(1));
            beat_valid = 1'b1;
            beat_data  = bdat(10 + i);
            beat_mask  = bmsk(10 + i);
        end
        @(negedge clk);
        check("R9 ready when full", 192'(beat_ready), 192'(0));
        beat_data = bdat(99);
        beat_mask = bmsk(99);
        @(negedge clk);
        beat_valid = 1'b0;
        mc_wreq_early = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k == 17) mc_wreq_early = 1'b0;
            if (k >= 3 && k <= 18) begin
                check("R9 drained data", 192'(mc_wdata), 192'(bdat(10 + k - 3)));
                check("R9 drained mask", 192'(mc_wmask), 192'(bmsk(10 + k - 3)));
            end
            if (k == 16) check("R7 no underrun yet", 192'(underrun), 192'(0));
            if (k == 17) check("R7 underrun set",    192'(underrun), 192'(1));
            if (k == 19) begin
                check("R7 empty slot data", 192'(mc_wdata), 192'(0));
                check("R7 empty slot mask", 192'(mc_wmask), 192'(18'h3FFFF));
            end
        end
        repeat (4) @(negedge clk);
        check("R7 underrun sticky", 192'(underrun), 192'(1));
        check("R5 len_err sticky",  192'(len_err),  192'(1));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule